// File: doc/BRIEF.md
# Shared-Function Bidirectional Port Controller

This block manages an eight-pin general-purpose port in which every pin can be taken over by a peripheral. A CPU-side bus writes a pin value register and a direction register, each with its own strobe, and reads back the synchronized pin levels. Peripheral enable inputs decide, pin by pin, whether the pin behaves as a GPIO or carries a peripheral signal. The peripherals are a two-wire serial bus, PWM channels and a clamp pulse.

The two lowest pins are open-drain and have no pull-up. They serve the serial bus's data and clock wires. Pins 2 to 6 are push-pull and each can carry one PWM channel. Pin 7 is push-pull and can carry either a sixth PWM channel or the clamp pulse. The block does not drive a pad directly. For each pin it produces three registered signals: an output value, an output enable and a pull-up enable. The pad cell, the resistor and the peripherals are outside the block.

Top module: `shared_pin_port`

## Requirements
- R1: Synchronous active-high reset clears the value and direction registers. While all peripheral enables are low after reset, every `pad_oe` bit is 0. `pad_pu` is 1 on pins 2 to 7 and 0 on pins 0 and 1.
- R2: Pins 0 and 1 in GPIO mode with their direction bit set are open-drain. `pad_out` is 0 and `pad_oe` is the inverse of the value bit.
- R3: Pins 0 and 1 in GPIO mode with their direction bit clear are inputs. `pad_oe`, `pad_out` and `pad_pu` are all 0.
- R4: While `sbus_en` is 1, pins 0 and 1 carry `sda_drv` and `scl_drv` respectively, whatever the register contents. The pin can only pull low: `pad_out` is 0 and `pad_oe` is the inverse of the peripheral value. `pad_pu` is 0.
- R5: Pins 2 to 6 in GPIO mode are push-pull. With the direction bit set, `pad_oe` is 1, `pad_out` is the value bit and `pad_pu` is 0. With the direction bit clear, `pad_oe` and `pad_out` are 0 and `pad_pu` is 1.
- R6: Pin k, for k from 2 to 6, is a PWM output while `pwm_en[k-2]` is 1. Then `pad_oe` is 1, `pad_out` is `pwm_val[k-2]` and `pad_pu` is 0, whatever the register contents.
- R7: Pin 7 is a GPIO, behaving as in R5, only while both `pwm_en[5]` and `clamp_en` are 0. When only `pwm_en[5]` is set, it drives `pwm_val[5]`. When `clamp_en` is set, it drives `clamp_val`, even if `pwm_en[5]` is also set. In both cases `pad_oe` is 1 and `pad_pu` is 0.
- R8: A write on `dat_we` loads only the value register from `wdata`. A write on `dir_we` loads only the direction register. Bit k of each register belongs to pin k. A register change shows on the pad signals at the second rising edge after the strobe is sampled.
- R9: Pad signals are registered. A change of a peripheral enable or value input shows on the pad signals one rising edge later.
- R10: `rdata` returns `pin_in` through a two-flop synchronizer. A change of `pin_in` appears on `rdata` after two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dat_we | input | 1 | Write strobe for the pin value register |
| dir_we | input | 1 | Write strobe for the direction register |
| wdata | input | 8 | CPU write data, bit k belongs to pin k |
| rdata | output | 8 | Synchronized pin levels |
| pin_in | input | 8 | Levels sensed at the pads |
| sbus_en | input | 1 | Hands pins 0 and 1 to the serial bus |
| sda_drv | input | 1 | Serial data value (0 pulls low) |
| scl_drv | input | 1 | Serial clock value (0 pulls low) |
| pwm_en | input | 6 | PWM enable for pins 2 to 7 |
| pwm_val | input | 6 | PWM levels for pins 2 to 7 |
| clamp_en | input | 1 | Hands pin 7 to the clamp pulse |
| clamp_val | input | 1 | Clamp pulse level |
| pad_out | output | 8 | Output value per pin |
| pad_oe | output | 8 | Output enable per pin |
| pad_pu | output | 8 | Pull-up enable per pin |

## Verification
The main sweep crosses many value and direction register patterns with 24 peripheral configurations. Each configuration differs in the serial-bus enable, the clamp enable, the PWM enable bits and the peripheral levels. A mismatch on pins 0 and 1 separates the open-drain rules from the push-pull rules. A pin that still follows the registers while its enable is set shows a missing takeover. Configurations that set the clamp and the pin-7 PWM together, with opposite levels, expose a wrong priority. A directed write on one strobe followed by a readback through the other register's effect shows whether the strobes are isolated. Single-step `pin_in` changes checked after one edge and after two edges pin down the synchronizer depth.

// File: rtl/port_pkg.sv
package port_pkg;
  typedef struct packed {
    logic out;
    logic oe;
    logic pu;
  } pad_drive_t;

  localparam pad_drive_t PAD_IDLE_OD = '{out: 1'b0, oe: 1'b0, pu: 1'b0};
  localparam pad_drive_t PAD_IDLE_PP = '{out: 1'b0, oe: 1'b0, pu: 1'b1};
endpackage

// File: rtl/port_regs.sv
module port_regs #(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dat_we,
  input  logic              dir_we,
  input  logic [N_PINS-1:0] wdata,
  output logic [N_PINS-1:0] dat_q,
  output logic [N_PINS-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dat_q <= '0;
      dir_q <= '0;
    end else begin
      if (dat_we) dat_q <= wdata;
      if (dir_we) dir_q <= wdata;
    end
  end

  // R1: reset leaves both registers empty
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (dat_q == '0 && dir_q == '0));

  // R8: each register moves only on its own strobe
  p_dat_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !dat_we |=> $stable(dat_q));
  p_dir_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !dir_we |=> $stable(dir_q));
endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int N_PINS = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] async_in,
  output logic [N_PINS-1:0] sync_out
);
  logic [N_PINS-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    chain[0] <= async_in;
    for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
  end

  assign sync_out = chain[STAGES-1];

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk
      // R10: two-edge delay from pad level to read data
      p_sync_delay_r10: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (sync_out == $past(async_in, 2)));
    end
  endgenerate
endmodule

// File: rtl/pin_cell.sv
module pin_cell
  import port_pkg::*;
#(
  parameter bit OPEN_DRAIN = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       gpio_dat,
  input  logic       gpio_dir,
  input  logic       alt_en,
  input  logic       alt_val,
  output pad_drive_t drv
);
  pad_drive_t drv_d;

  generate
    if (OPEN_DRAIN) begin : g_od
      always_comb begin
        drv_d.out = 1'b0;
        drv_d.pu  = 1'b0;
        if (alt_en) drv_d.oe = ~alt_val;
        else        drv_d.oe = gpio_dir & ~gpio_dat;
      end

      always_ff @(posedge clk) begin
        if (rst) drv <= PAD_IDLE_OD;
        else     drv <= drv_d;
      end

      // R4: peripheral drive on an open-drain pin pulls low only
      p_od_follow_r4: assert property (@(posedge clk) disable iff (rst)
        alt_en |=> (drv.oe == !$past(alt_val)) && !drv.out);
      // R3: GPIO input without pull-up
      p_od_no_pull_r3: assert property (@(posedge clk) disable iff (rst)
        (!alt_en && !gpio_dir) |=> (!drv.oe && !drv.pu));
      // R2: open-drain output never drives high
      p_od_low_only_r2: assert property (@(posedge clk) disable iff (rst)
        (!alt_en && gpio_dir && gpio_dat) |=> !drv.oe);
    end else begin : g_pp
      always_comb begin
        if (alt_en) begin
          drv_d.out = alt_val;
          drv_d.oe  = 1'b1;
          drv_d.pu  = 1'b0;
        end else begin
          drv_d.out = gpio_dat & gpio_dir;
          drv_d.oe  = gpio_dir;
          drv_d.pu  = ~gpio_dir;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) drv <= PAD_IDLE_PP;
        else     drv <= drv_d;
      end

      // R6: peripheral takes over the pin and disables the pull-up
      p_pp_alt_r6: assert property (@(posedge clk) disable iff (rst)
        alt_en |=> (drv.oe && !drv.pu && drv.out == $past(alt_val)));
      // R5: GPIO input enables the pull-up and releases the pin
      p_pp_pull_r5: assert property (@(posedge clk) disable iff (rst)
        (!alt_en && !gpio_dir) |=> (drv.pu && !drv.oe && !drv.out));
    end
  endgenerate
endmodule

// File: rtl/shared_pin_port.sv
module shared_pin_port
  import port_pkg::*;
#(
  parameter int              N_PINS      = 8,
  parameter logic [N_PINS-1:0] OD_MASK   = 8'b0000_0011,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dat_we,
  input  logic              dir_we,
  input  logic [N_PINS-1:0] wdata,
  output logic [N_PINS-1:0] rdata,
  input  logic [N_PINS-1:0] pin_in,
  input  logic              sbus_en,
  input  logic              sda_drv,
  input  logic              scl_drv,
  input  logic [N_PINS-3:0] pwm_en,
  input  logic [N_PINS-3:0] pwm_val,
  input  logic              clamp_en,
  input  logic              clamp_val,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  output logic [N_PINS-1:0] pad_pu
);
  localparam int N_PWM  = N_PINS - 2;
  localparam int TOP_PIN = N_PINS - 1;

  logic [N_PINS-1:0] dat_q, dir_q;
  logic [N_PINS-1:0] alt_en, alt_val;
  pad_drive_t        drv [N_PINS];

  port_regs #(.N_PINS(N_PINS)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .dat_we (dat_we),
    .dir_we (dir_we),
    .wdata  (wdata),
    .dat_q  (dat_q),
    .dir_q  (dir_q)
  );

  pin_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (rdata)
  );

  // Alternate-function routing: serial bus on pins 0/1, PWM on 2..top,
  // clamp shares the top pin and wins over its PWM channel.
  always_comb begin
    alt_en[0]  = sbus_en;
    alt_val[0] = sda_drv;
    alt_en[1]  = sbus_en;
    alt_val[1] = scl_drv;
    for (int k = 0; k < N_PWM - 1; k++) begin
      alt_en[k+2]  = pwm_en[k];
      alt_val[k+2] = pwm_val[k];
    end
    alt_en[TOP_PIN]  = pwm_en[N_PWM-1] | clamp_en;
    alt_val[TOP_PIN] = clamp_en ? clamp_val : pwm_val[N_PWM-1];
  end

  generate
    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
      pin_cell #(.OPEN_DRAIN(OD_MASK[g])) u_cell (
        .clk      (clk),
        .rst      (rst),
        .gpio_dat (dat_q[g]),
        .gpio_dir (dir_q[g]),
        .alt_en   (alt_en[g]),
        .alt_val  (alt_val[g]),
        .drv      (drv[g])
      );
      assign pad_out[g] = drv[g].out;
      assign pad_oe[g]  = drv[g].oe;
      assign pad_pu[g]  = drv[g].pu;
    end
  endgenerate

  // R7: clamp wins over the PWM channel on the shared top pin
  p_clamp_prio_r7: assert property (@(posedge clk) disable iff (rst)
    (clamp_en && pwm_en[N_PWM-1]) |=>
      (pad_out[TOP_PIN] == $past(clamp_val) && pad_oe[TOP_PIN]));

  // R9: pins 0/1 follow the serial bus one edge after it is enabled
  p_sbus_take_r9: assert property (@(posedge clk) disable iff (rst)
    sbus_en |=> (pad_oe[1:0] == ~{$past(scl_drv), $past(sda_drv)}));
endmodule

// File: tb/sim_shared_pin_port.sv
module sim_shared_pin_port;
  logic       clk = 1'b0;
  logic       rst;
  logic       dat_we, dir_we;
  logic [7:0] wdata, rdata, pin_in;
  logic       sbus_en, sda_drv, scl_drv, clamp_en, clamp_val;
  logic [5:0] pwm_en, pwm_val;
  logic [7:0] pad_out, pad_oe, pad_pu;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  shared_pin_port u0 (
    .clk(clk), .rst(rst), .dat_we(dat_we), .dir_we(dir_we), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .sbus_en(sbus_en), .sda_drv(sda_drv),
    .scl_drv(scl_drv), .pwm_en(pwm_en), .pwm_val(pwm_val),
    .clamp_en(clamp_en), .clamp_val(clamp_val),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input bit to_dir, input logic [7:0] v);
    @(negedge clk);
    wdata = v;
    if (to_dir) dir_we = 1'b1; else dat_we = 1'b1;
    @(negedge clk);
    dat_we = 1'b0;
    dir_we = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  // Expected pad signals, from the requirements
  task automatic model(input logic [7:0] dat, input logic [7:0] dir,
                       output logic [7:0] e_out, output logic [7:0] e_oe,
                       output logic [7:0] e_pu);
    for (int k = 0; k < 8; k++) begin
      logic a, v;
      if (k < 2) begin
        a = sbus_en;
        v = (k == 0) ? sda_drv : scl_drv;
        e_out[k] = 1'b0;
        e_pu[k]  = 1'b0;
        e_oe[k]  = a ? ~v : (dir[k] & ~dat[k]);
      end else begin
        if (k < 7) begin
          a = pwm_en[k-2];
          v = pwm_val[k-2];
        end else begin
          a = pwm_en[5] | clamp_en;
          v = clamp_en ? clamp_val : pwm_val[5];
        end
        e_out[k] = a ? v : (dat[k] & dir[k]);
        e_oe[k]  = a ? 1'b1 : dir[k];
        e_pu[k]  = a ? 1'b0 : ~dir[k];
      end
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] e_out, e_oe, e_pu;
    rst = 1'b1; dat_we = 0; dir_we = 0; wdata = 0; pin_in = 0;
    sbus_en = 0; sda_drv = 1; scl_drv = 1; pwm_en = 0; pwm_val = 0;
    clamp_en = 0; clamp_val = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "pad_oe", pad_oe, 8'h00);
    check("R1", "pad_pu", pad_pu, 8'hFC);
    check("R1", "pad_out", pad_out, 8'h00);

    // R8: strobes isolated, and two-edge latency
    wr(1'b1, 8'hFF);
    wr(1'b0, 8'hA5);
    settle();
    check("R8", "pad_out after value write", pad_out, 8'hA4);
    check("R2", "pad_oe open-drain low only", pad_oe, 8'hFE);
    @(negedge clk);
    wdata = 8'h3C; dir_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dir_we = 1'b0;
    check("R8", "pad_oe unchanged one edge after strobe", pad_oe, 8'hFE);
    @(negedge clk);
    check("R8", "pad_oe after direction write", pad_oe, 8'h3C);
    check("R8", "value kept across direction write", pad_out, 8'h24);
    check("R3", "pad_pu on input pins", pad_pu, 8'hC0);

    // R9: one-edge latency of a peripheral enable
    @(negedge clk);
    pwm_en = 6'h01; pwm_val = 6'h00;
    @(negedge clk);
    check("R9", "pin 2 taken over one edge later", pad_out & 8'h04, 8'h00);
    pwm_val = 6'h01;
    @(negedge clk);
    check("R6", "pin 2 follows PWM", pad_out & 8'h04, 8'h04);

    // R7 priority: clamp and PWM both on, opposite levels
    pwm_en = 6'h20; pwm_val = 6'h20; clamp_en = 1; clamp_val = 0;
    @(negedge clk);
    check("R7", "clamp wins on pin 7", pad_out & 8'h80, 8'h00);
    clamp_val = 1; pwm_val = 6'h00;
    @(negedge clk);
    check("R7", "clamp level 1 on pin 7", pad_out & 8'h80, 8'h80);

    // Main sweep: R2 R3 R4 R5 R6 R7
    for (int m = 0; m < 24; m++) begin
      sbus_en   = m[0];
      clamp_en  = m[1];
      sda_drv   = m[2];
      scl_drv   = ~m[3];
      pwm_en    = 6'((m * 13) ^ (m >> 1));
      pwm_val   = 6'(m * 7 + 3);
      clamp_val = m[4] ^ m[0];
      for (int j = 0; j < 10; j++) begin
        logic [7:0] d, r;
        d = 8'(j * 53 + m * 11);
        r = 8'(j * 29 + m * 5) ^ 8'hC3;
        wr(1'b0, d);
        wr(1'b1, r);
        settle();
        model(d, r, e_out, e_oe, e_pu);
        check("R2 R3 R4 R5 R6 R7", "sweep pad_out", pad_out, e_out);
        check("R2 R3 R4 R5 R6 R7", "sweep pad_oe", pad_oe, e_oe);
        check("R2 R3 R4 R5 R6 R7", "sweep pad_pu", pad_pu, e_pu);
      end
    end

    // R10: synchronizer depth
    for (int i = 0; i < 16; i++) begin
      logic [7:0] prev, nxt;
      prev = pin_in;
      nxt  = 8'(i * 37 + 1) ^ prev;
      @(negedge clk);
      pin_in = nxt;
      @(posedge clk);
      @(negedge clk);
      check("R10", "rdata after one edge", rdata, prev);
      @(negedge clk);
      check("R10", "rdata after two edges", rdata, nxt);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule